// File: doc/BRIEF.md
# Sliced-Memory Prefetch Read FIFO

This block keeps a stream of sequential 32-bit words flowing from a shared memory that is cut into `SLICES` interleaved slices (1, 2, 4, 8 or 16). Access to the slices rotates by one slice per clock. A read may go out only on a clock when the rotation points at the slice that holds the wanted word. Each read comes back after a fixed pipeline delay. The block issues back-to-back word reads, follows the reads that are still in the pipeline, and buffers the returned words for a consumer that may take one word on any clock and can never be made to wait.

The consumer is an instruction fetcher or a data streamer. A restart (a branch or a loop restart) throws away the buffered words and the reads still in the pipeline. It then starts a fresh sequential fetch from a new word address. The consumer may begin as soon as the first new word shows valid. The refill stop level and the storage depth both follow from the slice count and the read latency. Together they make sure a consumer that waits only for that first word never finds the buffer empty. Sticky error flags and an occupancy count make any breach of that rule visible.

Top module: `hub_prefetch_fifo`

## Requirements
- R1: After reset, `occupancy` is 0, `word_valid` is 0, both error flags are 0, and no read is issued until the first restart.
- R2: Storage holds `SLICES`+2*`LAT`-1 words (`SLICES`+11 with the default `LAT` of 6). With no pops after a restart, occupancy settles at exactly that value and `overflow_err` stays 0.
- R3: A read is issued only while occupancy is below `SLICES`+`LAT` (`SLICES`+6). With no pops after a restart, exactly `SLICES`+11 reads are issued and then issuing stops.
- R4: The rotation position is 0 in the first cycle after reset release and advances by 1 modulo `SLICES` each clock. A word address lives in slice (address mod `SLICES`). `rd_req` is high only when that slice of `rd_addr` equals the rotation position. After a restart, the first read goes to `restart_addr` in the first aligned cycle, and further reads follow at consecutive addresses.
- R5: A word read in cycle t is taken from `rd_data` in cycle t+5. It is visible (`word_valid`, `occupancy`) in cycle t+6. It is usable at once, without waiting for the buffer to fill.
- R6: `word_out` presents the words in the order they were read. A `pop` removes the head word.
- R7: While `restart` is high, no read is issued and a `pop` is ignored. In the next cycle, occupancy is 0 and `word_valid` is 0. No word from a read issued before the restart is ever delivered. The first word delivered comes from `restart_addr`.
- R8: Once the first word after a restart is valid, any pattern of pops (at most one per clock, including pops on alternate clocks and random bursts) never finds the buffer empty. `underflow_err` stays 0 for every allowed `SLICES`.
- R9: A pop while occupancy is 0 (and `restart` low) leaves occupancy at 0. It sets `underflow_err`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Flush and begin fetching at `restart_addr` |
| restart_addr | input | AW | New word address |
| pop | input | 1 | Consumer removes the head word |
| word_out | output | DW | Head word |
| word_valid | output | 1 | Buffer is not empty |
| occupancy | output | $clog2(SLICES+2*LAT) | Words currently buffered |
| rd_req | output | 1 | Memory read issued this cycle |
| rd_addr | output | AW | Word address of the read |
| rd_data | input | DW | Returning word, LAT-1 cycles after its request |
| underflow_err | output | 1 | Sticky: pop met an empty buffer |
| overflow_err | output | 1 | Sticky: returning word met a full buffer |

## Verification
Every result is due a fixed number of cycles after its cause:
- A read issued in cycle t must show valid in cycle t+6, and must still be invisible in cycle t+5.
- The first issue after a restart must fall on the first cycle whose rotation position matches the slice of `restart_addr`. The bench predicts that cycle from its own cycle count.
- Restart and empty-pop effects are due in the very next cycle.

The bench steps one cycle at a time. It drives inputs at the falling edge and reads all outputs 2 ns later, in the same cycle as the expected effect, so the count of registers on each path sets exactly which step is checked.

// File: rtl/hub_prefetch_fifo.sv
module hub_prefetch_fifo #(
  parameter int SLICES = 16,
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int LAT    = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               restart,
  input  logic [AW-1:0]                      restart_addr,
  input  logic                               pop,
  output logic [DW-1:0]                      word_out,
  output logic                               word_valid,
  output logic [$clog2(SLICES+2*LAT)-1:0]    occupancy,
  output logic                               rd_req,
  output logic [AW-1:0]                      rd_addr,
  input  logic [DW-1:0]                      rd_data,
  output logic                               underflow_err,
  output logic                               overflow_err
);

  localparam int FULL  = SLICES + LAT;
  localparam int DEPTH = FULL + LAT - 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int PW    = $clog2(DEPTH);
  localparam int SW    = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic          active;
  logic          aligned;
  logic [LAT-2:0] inflight;
  logic [CW-1:0] cnt;
  logic [PW-1:0] rptr, wptr;
  logic [DW-1:0] store [DEPTH];
  logic          do_pop, do_wr, ret;

  generate
    if (SLICES == 1) begin : g_single
      assign aligned = 1'b1;
    end else begin : g_rotate
      logic [SW-1:0] pos;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pos <= '0;
        else        pos <= pos + 1'b1;
      assign aligned = (rd_addr[SW-1:0] == pos);
    end
  endgenerate

  assign rd_req = active && !restart && (cnt < CW'(FULL)) && aligned;
  assign ret    = inflight[LAT-2];
  assign do_pop = pop && !restart && (cnt != '0);
  assign do_wr  = ret && !restart && ((cnt != CW'(DEPTH)) || do_pop);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active   <= 1'b0;
      rd_addr  <= '0;
      inflight <= '0;
    end else if (restart) begin
      active   <= 1'b1;
      rd_addr  <= restart_addr;
      inflight <= '0;
    end else begin
      rd_addr  <= rd_addr + AW'(rd_req);
      inflight <= {inflight[LAT-3:0], rd_req};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      rptr <= '0;
      wptr <= '0;
    end else if (restart) begin
      cnt  <= '0;
      rptr <= '0;
      wptr <= '0;
    end else begin
      if (do_wr)  wptr <= bump(wptr);
      if (do_pop) rptr <= bump(rptr);
      if (do_wr && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_wr) cnt <= cnt - 1'b1;
    end

  always_ff @(posedge clk)
    if (do_wr) store[wptr] <= rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      underflow_err <= 1'b0;
      overflow_err  <= 1'b0;
    end else begin
      if (pop && !restart && cnt == '0) underflow_err <= 1'b1;
      if (ret && !restart && cnt == CW'(DEPTH) && !do_pop) overflow_err <= 1'b1;
    end

  assign word_out   = store[rptr];
  assign word_valid = (cnt != '0);
  assign occupancy  = cnt;

endmodule

// File: rtl/hub_prefetch_fifo_chk.sv
module hub_prefetch_fifo_chk #(
  parameter int SLICES = 16,
  parameter int LAT    = 6,
  parameter int AW     = 16,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          pop,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic [CW-1:0] occupancy,
  input logic          word_valid,
  input logic          underflow_err,
  input logic          overflow_err
);
  localparam int FULL  = SLICES + LAT;
  localparam int DEPTH = FULL + LAT - 1;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !overflow_err); // R2

  AST_STOP_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> occupancy < CW'(FULL)); // R3

  AST_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && $past(rd_req)) |-> rd_addr == AW'($past(rd_addr) + 1'b1)); // R4

  AST_RESTART_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !rd_req); // R7

  AST_RESTART_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (occupancy == '0 && !word_valid)); // R7

  AST_EMPTY_POP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !restart && occupancy == '0) |=> (underflow_err && occupancy == '0)); // R9

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err); // R9
endmodule

bind hub_prefetch_fifo hub_prefetch_fifo_chk #(
  .SLICES(SLICES), .LAT(LAT), .AW(AW), .CW($clog2(SLICES + 2*LAT))
) u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .pop(pop), .rd_req(rd_req),
  .rd_addr(rd_addr), .occupancy(occupancy), .word_valid(word_valid),
  .underflow_err(underflow_err), .overflow_err(overflow_err)
);

// File: tb/sim_hub_prefetch_fifo.sv
module sim_lane #(parameter int N = 1) (
  input  logic clk,
  output int   n_chk,
  output int   n_bad,
  output logic done
);
  localparam int AW    = 16;
  localparam int LAT   = 6;
  localparam int DEPTH = N + 2*LAT - 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          rst_n, restart, pop;
  logic [AW-1:0] restart_addr, rd_addr;
  logic [31:0]   word_out, rd_data;
  logic          word_valid, rd_req, underflow_err, overflow_err;
  logic [CW-1:0] occupancy;
  logic [AW-1:0] pa [LAT-1];
  int            cyc, issues, last_issue;
  logic [15:0]   lfsr;
  logic [AW-1:0] exp_a;

  function automatic logic [31:0] fw(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  hub_prefetch_fifo #(.SLICES(N), .AW(AW), .DW(32), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .restart_addr(restart_addr),
    .pop(pop), .word_out(word_out), .word_valid(word_valid), .occupancy(occupancy),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .underflow_err(underflow_err), .overflow_err(overflow_err)
  );

  always @(posedge clk) begin
    pa[0] <= rd_addr;
    for (int i = 1; i < LAT-1; i++) pa[i] <= pa[i-1];
  end
  assign rd_data = fw(pa[LAT-2]);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint got, input longint want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s N=%0d %s: actual %0h expected %0h", tag, N, what, got, want);
    end
  endtask

  task automatic tick(input logic p, input logic r, input logic [AW-1:0] a);
    @(negedge clk);
    pop = p; restart = r; restart_addr = a;
    #2;
    if (rd_req) begin
      issues++;
      last_issue = cyc;
      chk(int'(rd_addr) % N == cyc % N, "R4", "read slice vs rotation",
          int'(rd_addr) % N, cyc % N);
    end
  endtask

  task automatic consume(input logic p);
    tick(p, 1'b0, '0);
    if (p) begin
      chk(word_valid, "R8", "pop found buffer empty", word_valid, 1);
      chk(word_out == fw(exp_a), "R6", "popped word", word_out, fw(exp_a));
      exp_a = exp_a + 1'b1;
    end
  endtask

  task automatic wait_first(input string tag);
    int k;
    k = 0;
    tick(1'b0, 1'b0, '0);
    while (!word_valid && k < 100) begin
      chk(occupancy == '0, tag, "stale word before first", occupancy, 0);
      tick(1'b0, 1'b0, '0);
      k++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pop = 1'b0; restart = 1'b0; restart_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    issues = 0;
    repeat (10) tick(1'b0, 1'b0, '0);
    chk(occupancy == '0, "R1", "occupancy after reset", occupancy, 0);
    chk(!word_valid, "R1", "valid after reset", word_valid, 0);
    chk(issues == 0, "R1", "reads before restart", issues, 0);
    chk(!underflow_err && !overflow_err, "R1", "flags after reset",
        {underflow_err, overflow_err}, 0);
  endtask

  task automatic t_fill(input logic [AW-1:0] a);
    int c0, k0, first;
    tick(1'b0, 1'b1, a);
    chk(!rd_req, "R7", "read during restart", rd_req, 0);
    c0 = cyc;
    k0 = 1;
    while ((c0 + k0) % N != int'(a) % N) k0++;
    issues = 0;
    first = -1;
    for (int k = 0; k < 80; k++) begin
      tick(1'b0, 1'b0, '0);
      if (rd_req && first < 0) begin
        first = cyc;
        chk(rd_addr == a, "R4", "first read address", rd_addr, a);
        chk(first == c0 + k0, "R4", "first aligned cycle", first, c0 + k0);
      end
      if (first >= 0 && cyc == first + 5)
        chk(!word_valid, "R5", "valid one cycle early", word_valid, 0);
      if (first >= 0 && cyc == first + 6) begin
        chk(word_valid, "R5", "valid at issue+6", word_valid, 1);
        chk(word_out == fw(a), "R5", "first word", word_out, fw(a));
      end
    end
    chk(occupancy == CW'(DEPTH), "R2", "settled occupancy", occupancy, DEPTH);
    chk(issues == DEPTH, "R3", "reads with no pops", issues, DEPTH);
    chk(last_issue < cyc - 20, "R3", "issuing stopped", last_issue, cyc - 20);
    chk(!overflow_err, "R2", "overflow flag", overflow_err, 0);
    exp_a = a;
  endtask

  task automatic t_drain();
    for (int i = 0; i < 3*DEPTH; i++) consume(1'b1);
  endtask

  task automatic t_ifetch();
    for (int i = 0; i < 200; i++) consume(i % 2 == 0);
  endtask

  task automatic t_restart(input logic [AW-1:0] b);
    for (int i = 0; i < 37; i++) consume(i % 3 != 1);
    tick(1'b1, 1'b1, b);
    chk(!rd_req, "R7", "read during restart", rd_req, 0);
    tick(1'b0, 1'b0, '0);
    chk(occupancy == '0 && !word_valid, "R7", "flushed after restart", occupancy, 0);
    exp_a = b;
    wait_first("R7");
    chk(word_out == fw(b), "R7", "first word after restart", word_out, fw(b));
    chk(!underflow_err, "R7", "pop at restart ignored", underflow_err, 0);
  endtask

  task automatic t_random(input logic [AW-1:0] a, input int len);
    int left;
    logic mode;
    left = 0; mode = 1'b0;
    tick(1'b0, 1'b1, a);
    exp_a = a;
    wait_first("R7");
    for (int i = 0; i < len; i++) begin
      if (left == 0) begin
        mode = lfsr[0];
        left = int'(lfsr[5:1]) % 30 + 1;
      end
      consume(mode);
      left--;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    chk(!underflow_err, "R8", "underflow after random bursts", underflow_err, 0);
    chk(!overflow_err, "R2", "overflow after random bursts", overflow_err, 0);
  endtask

  task automatic t_empty_pop(input logic [AW-1:0] e);
    tick(1'b0, 1'b1, e);
    tick(1'b1, 1'b0, '0);
    tick(1'b0, 1'b0, '0);
    chk(occupancy == '0, "R9", "occupancy after empty pop", occupancy, 0);
    chk(underflow_err, "R9", "underflow set", underflow_err, 1);
    repeat (20) tick(1'b0, 1'b0, '0);
    chk(underflow_err, "R9", "underflow sticky", underflow_err, 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    issues = 0; last_issue = 0; exp_a = '0;
    lfsr = 16'hACE1 ^ 16'(N);
    t_reset();
    t_fill(16'h0103);
    t_drain();
    t_ifetch();
    t_restart(16'h2207);
    t_random(16'h4E0D, 2500);
    t_empty_pop(16'h0011);
    done = 1'b1;
  end
endmodule

module sim_hub_prefetch_fifo;
  logic       clk = 1'b0;
  int         c [5];
  int         b [5];
  logic [4:0] done;
  int         tot, bad;
  bit         timeout;

  always #5 clk = ~clk;

  generate
    for (genvar g = 0; g < 5; g++) begin : g_lane
      sim_lane #(.N(1 << g)) u_lane (.clk(clk), .n_chk(c[g]), .n_bad(b[g]), .done(done[g]));
    end
  endgenerate

  initial begin
    tot = 0; bad = 0; timeout = 1'b1;
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (&done) begin
        timeout = 1'b0;
        break;
      end
    end
    #1;
    for (int i = 0; i < 5; i++) begin
      tot += c[i];
      bad += b[i];
    end
    if (timeout) begin
      tot++; bad++;
      $display("FAIL watchdog: lanes done %b expected %b", done, 5'b11111);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", tot, bad);
    $finish;
  end
endmodule